// File: doc/BRIEF.md
# GPIO Bank Output Register with Half-Word Masked Writes

This block keeps the output state of one bank of general-purpose pins: the value each pin drives, whether each pin is an output, and a separate per-pin output-enable. Software can replace the whole output word in one write. It can also use one of two half-word masked-write ports to change any chosen subset of pins without reading the register first. One port serves the lower half of the pins and the other serves the upper half. Each masked write carries a per-pin keep mask in its upper half and the new pin values in its lower half.

A pin's driver is switched on only when both its direction bit and its output-enable bit are set. The pad input levels pass through a small synchronizer and can be read back, together with the stored registers, through a combinational read selector. Bus protocol, interrupt logic and decoding across several banks sit outside this block.

Top module: `gpio_bank_regs`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the output data, direction and output-enable registers all clear to 0, so `pad_out` and `pad_drive` read 0 after reset.
- R2: A full-word write (`full_we`) loads all WIDTH bits of `full_wdata` into the output data, visible on `pad_out` after the next rising edge.
- R3: A low masked write (`lo_we`) acts on pins 0 to 15 only. `lo_wdata[31:16]` is the keep mask and `lo_wdata[15:0]` holds the new values. Where a mask bit is 0, the pin takes the new bit. Where it is 1, the pin keeps its value. Pins 16 to 31 are unchanged.
- R4: A high masked write (`hi_we`) uses the same word layout as R3 and acts on pins 16 to 31 only: data bit k goes to pin 16+k under mask bit 16+k. Pins 0 to 15 are unchanged.
- R5: If a full-word write and any masked write fall in the same cycle, the full-word write alone decides the new output data.
- R6: Low and high masked writes in the same cycle, with no full-word write, both take effect, each on its own half.
- R7: `dir_we` loads `dir_wdata` into the direction register (1 = output, 0 = input). It reads back on `rd_sel` = 3.
- R8: `oen_we` loads `oen_wdata` into the output-enable register, which is independent of direction. It reads back on `rd_sel` = 4.
- R9: `pad_drive[i]` is 1 exactly when direction bit i and output-enable bit i are both 1. `pad_out` always shows the output data register.
- R10: `rd_sel` = 0 returns the full output data. `rd_sel` = 1 returns data bits 15:0 in `rd_data[15:0]`, and `rd_sel` = 2 returns data bits 31:16 there. For selects 1 and 2, `rd_data[31:16]` is 0.
- R11: `rd_sel` = 5 returns `pad_in` as it was sampled two rising edges earlier, through a two-stage synchronizer.
- R12: `rd_sel` values 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| full_we | input | 1 | Full-word data write strobe |
| full_wdata | input | 32 | Full-word data value |
| lo_we | input | 1 | Low-half masked write strobe |
| lo_wdata | input | 32 | Keep mask [31:16], values for pins 15:0 in [15:0] |
| hi_we | input | 1 | High-half masked write strobe |
| hi_wdata | input | 32 | Keep mask [31:16], values for pins 31:16 in [15:0] |
| dir_we | input | 1 | Direction register write strobe |
| dir_wdata | input | 32 | Direction value, 1 = output |
| oen_we | input | 1 | Output-enable register write strobe |
| oen_wdata | input | 32 | Output-enable value |
| rd_sel | input | 3 | Read select: 0 data, 1 low view, 2 high view, 3 direction, 4 enable, 5 pads |
| rd_data | output | 32 | Combinational read data |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Output data toward the pads |
| pad_drive | output | 32 | Per-pin driver enable |

## Verification
Each masked port is swept one pin at a time in both directions: set the pin through an all-ones value word, then clear it through an all-zeros word. This separates a correct mask polarity and correct half selection from swapped or shifted ones. Multi-bit mask and data mixes then start from a non-trivial value to catch logic that merges with the wrong operand. A walking one through the full-word port and same-cycle collisions between all three data ports expose priority and lane-crossing faults. Direction and enable are set to patterns that together cover all four bit combinations on each pin, which catches a driver enable that uses OR or ignores one register.

// File: rtl/gpio_bank_pkg.sv
// Shared definitions for the GPIO bank register block.
// Assumes a 3-bit read selector; unlisted codes read as zero.
package gpio_bank_pkg;
    typedef enum logic [2:0] {
        RSEL_DATA    = 3'd0,
        RSEL_LO_VIEW = 3'd1,
        RSEL_HI_VIEW = 3'd2,
        RSEL_DIR     = 3'd3,
        RSEL_OEN     = 3'd4,
        RSEL_PADS    = 3'd5
    } rd_sel_e;
endpackage

// File: rtl/gpio_out_data.sv
// Output data register with one full-word write and two half-word masked writes.
// Assumes WIDTH is even; each masked word carries a keep mask in its upper
// half and new values in its lower half. Full-word write has priority.
module gpio_out_data #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_we,
    input  logic [WIDTH-1:0] full_wdata,
    input  logic             lo_we,
    input  logic [WIDTH-1:0] lo_wdata,
    input  logic             hi_we,
    input  logic [WIDTH-1:0] hi_wdata,
    output logic [WIDTH-1:0] data_q
);
    localparam int HALF = WIDTH / 2;

    logic [1:0]       part_we;
    logic [WIDTH-1:0] part_word [2];
    logic [WIDTH-1:0] merged;

    assign part_we      = {hi_we, lo_we};
    assign part_word[0] = lo_wdata;
    assign part_word[1] = hi_wdata;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF-1:0] keep;
        logic [HALF-1:0] val;
        logic [HALF-1:0] cur;
        assign keep = part_word[h][WIDTH-1:HALF];
        assign val  = part_word[h][HALF-1:0];
        assign cur  = data_q[h*HALF +: HALF];
        // Merge new values into unmasked pins of this half.
        always_comb begin
            if (part_we[h]) merged[h*HALF +: HALF] = (cur & keep) | (val & ~keep);
            else            merged[h*HALF +: HALF] = cur;
        end
    end

    // Register update: reset, full-word write, or merged masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (full_we) data_q <= full_wdata;
        else              data_q <= merged;
    end

    // R2 R5
    full_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_we |=> data_q == $past(full_wdata));

    // R3
    lo_keep_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && lo_we) |=>
        ((data_q[HALF-1:0] ^ $past(data_q[HALF-1:0])) & $past(lo_wdata[WIDTH-1:HALF])) == '0);

    // R3
    lo_take_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && lo_we) |=>
        ((data_q[HALF-1:0] ^ $past(lo_wdata[HALF-1:0])) & ~$past(lo_wdata[WIDTH-1:HALF])) == '0);

    // R4
    hi_take_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && hi_we) |=>
        ((data_q[WIDTH-1:HALF] ^ $past(hi_wdata[HALF-1:0])) & ~$past(hi_wdata[WIDTH-1:HALF])) == '0);

    // R4
    hi_untouched_by_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && !hi_we) |=> $stable(data_q[WIDTH-1:HALF]));

    // R3
    lo_untouched_by_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_we && !lo_we) |=> $stable(data_q[HALF-1:0]));
endmodule

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for the raw pad inputs.
// Assumes STAGES >= 1; the output lags pad_in by STAGES rising edges.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pads_q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift pad levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= pad_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign pads_q = stage_q[STAGES-1];

    for (genvar s = 1; s < STAGES; s++) begin : g_chk
        // R11
        stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> stage_q[s] == $past(stage_q[s-1]));
    end
endmodule

// File: rtl/gpio_bank_regs.sv
// One GPIO bank: output data, direction, output enable, pad readback.
// Assumes a combinational read selected by rd_sel and synchronous writes.
// A pin drives only when its direction and output-enable bits are both 1.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full_we,
    input  logic [WIDTH-1:0] full_wdata,
    input  logic             lo_we,
    input  logic [WIDTH-1:0] lo_wdata,
    input  logic             hi_we,
    input  logic [WIDTH-1:0] hi_wdata,
    input  logic             dir_we,
    input  logic [WIDTH-1:0] dir_wdata,
    input  logic             oen_we,
    input  logic [WIDTH-1:0] oen_wdata,
    input  logic [2:0]       rd_sel,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_drive
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] oen_q;
    logic [WIDTH-1:0] pads_q;

    gpio_out_data #(.WIDTH(WIDTH)) i_out_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .full_we    (full_we),
        .full_wdata (full_wdata),
        .lo_we      (lo_we),
        .lo_wdata   (lo_wdata),
        .hi_we      (hi_we),
        .hi_wdata   (hi_wdata),
        .data_q     (data_q)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_in_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .pads_q (pads_q)
    );

    // Direction register, 1 = output.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (dir_we) dir_q <= dir_wdata;
    end

    // Output-enable register, independent of direction.
    always_ff @(posedge clk) begin
        if (!rst_n)      oen_q <= '0;
        else if (oen_we) oen_q <= oen_wdata;
    end

    assign pad_out   = data_q;
    assign pad_drive = dir_q & oen_q;

    // Read multiplexer; half views are zero-extended.
    always_comb begin
        rd_data = '0;
        case (rd_sel_e'(rd_sel))
            RSEL_DATA:    rd_data = data_q;
            RSEL_LO_VIEW: rd_data[HALF-1:0] = data_q[HALF-1:0];
            RSEL_HI_VIEW: rd_data[HALF-1:0] = data_q[WIDTH-1:HALF];
            RSEL_DIR:     rd_data = dir_q;
            RSEL_OEN:     rd_data = oen_q;
            RSEL_PADS:    rd_data = pads_q;
            default:      rd_data = '0;
        endcase
    end

    // R7
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we |=> dir_q == $past(dir_wdata));

    // R8
    oen_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oen_we |=> oen_q == $past(oen_wdata));

    // R9
    drive_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_we && oen_we) |=> pad_drive == ($past(dir_wdata) & $past(oen_wdata)));

    // R10
    view_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 3'd1 || rd_sel == 3'd2) |-> rd_data[WIDTH-1:HALF] == '0);
endmodule

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic full_we = 1'b0, lo_we = 1'b0, hi_we = 1'b0, dir_we = 1'b0, oen_we = 1'b0;
    logic [W-1:0] full_wdata = '0, lo_wdata = '0, hi_wdata = '0;
    logic [W-1:0] dir_wdata = '0, oen_wdata = '0, pad_in = '0;
    logic [2:0]   rd_sel = 3'd0;
    logic [W-1:0] rd_data, pad_out, pad_drive;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] model = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_bank_regs i_gpio_bank_regs (
        .clk(clk), .rst_n(rst_n),
        .full_we(full_we), .full_wdata(full_wdata),
        .lo_we(lo_we), .lo_wdata(lo_wdata),
        .hi_we(hi_we), .hi_wdata(hi_wdata),
        .dir_we(dir_we), .dir_wdata(dir_wdata),
        .oen_we(oen_we), .oen_wdata(oen_wdata),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_drive(pad_drive)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        full_we = 1'b0; lo_we = 1'b0; hi_we = 1'b0; dir_we = 1'b0; oen_we = 1'b0;
    endtask

    function automatic logic [15:0] merge16(logic [15:0] old, logic [15:0] keep, logic [15:0] val);
        return (old & keep) | (val & ~keep);
    endfunction

    task automatic lo_write(input logic [15:0] keep, input logic [15:0] val);
        lo_we = 1'b1; lo_wdata = {keep, val};
        tick();
        model[15:0] = merge16(model[15:0], keep, val);
    endtask

    task automatic hi_write(input logic [15:0] keep, input logic [15:0] val);
        hi_we = 1'b1; hi_wdata = {keep, val};
        tick();
        model[31:16] = merge16(model[31:16], keep, val);
    endtask

    task automatic read_check(input string req, input logic [2:0] sel, input logic [W-1:0] exp);
        rd_sel = sel;
        #1;
        check(req, rd_data, exp);
    endtask

    initial begin
        #1;
        // R1: reset
        repeat (3) tick();
        check("R1 data", pad_out, '0);
        check("R1 drive", pad_drive, '0);
        read_check("R1 dir", 3'd3, '0);
        read_check("R1 oen", 3'd4, '0);
        rst_n = 1'b1;
        tick();

        // R2: walking one and patterns through the full-word port
        for (int i = 0; i < W; i++) begin
            full_we = 1'b1; full_wdata = 32'h1 << i;
            tick();
            model = 32'h1 << i;
            check("R2 walk", pad_out, model);
        end
        full_we = 1'b1; full_wdata = 32'h1234_5678; tick(); model = 32'h1234_5678;
        read_check("R2 R10 full read", 3'd0, model);

        // R3: per-pin set then clear through low port
        for (int p = 0; p < 16; p++) begin
            lo_write(~(16'h1 << p), 16'hFFFF);
            check("R3 set", pad_out, model);
            lo_write(~(16'h1 << p), 16'h0000);
            check("R3 clear", pad_out, model);
        end
        lo_write(16'h00FF, 16'hA5C3);
        check("R3 mix", pad_out, model);
        lo_write(16'hF0F0, 16'h3C3C);
        check("R3 mix2", pad_out, model);
        read_check("R10 lo view", 3'd1, {16'h0, model[15:0]});

        // R4: per-pin set then clear through high port
        for (int p = 0; p < 16; p++) begin
            hi_write(~(16'h1 << p), 16'hFFFF);
            check("R4 set", pad_out, model);
            hi_write(~(16'h1 << p), 16'h0000);
            check("R4 clear", pad_out, model);
        end
        hi_write(16'h0F0F, 16'h9E71);
        check("R4 mix", pad_out, model);
        read_check("R10 hi view", 3'd2, {16'h0, model[31:16]});

        // R6: both masked ports in one cycle
        lo_we = 1'b1; lo_wdata = {16'hFF00, 16'h00AA};
        hi_we = 1'b1; hi_wdata = {16'h00FF, 16'h5500};
        tick();
        model[15:0]  = merge16(model[15:0], 16'hFF00, 16'h00AA);
        model[31:16] = merge16(model[31:16], 16'h00FF, 16'h5500);
        check("R6 both halves", pad_out, model);

        // R5: full-word write collides with both masked writes
        full_we = 1'b1; full_wdata = 32'hCAFE_F00D;
        lo_we = 1'b1; lo_wdata = 32'h0000_1111;
        hi_we = 1'b1; hi_wdata = 32'h0000_2222;
        tick();
        model = 32'hCAFE_F00D;
        check("R5 priority", pad_out, model);

        // R7 R8 R9: direction and enable cover all four combinations per pin
        dir_we = 1'b1; dir_wdata = 32'hAAAA_AAAA; tick();
        read_check("R7 dir", 3'd3, 32'hAAAA_AAAA);
        check("R9 dir only", pad_drive, '0);
        oen_we = 1'b1; oen_wdata = 32'hCCCC_CCCC; tick();
        read_check("R8 oen", 3'd4, 32'hCCCC_CCCC);
        check("R9 drive", pad_drive, 32'hAAAA_AAAA & 32'hCCCC_CCCC);
        check("R9 out", pad_out, model);
        dir_we = 1'b1; dir_wdata = 32'hFFFF_0000;
        oen_we = 1'b1; oen_wdata = 32'h00FF_FF00; tick();
        check("R9 drive2", pad_drive, 32'h00FF_0000);

        // R11: two-edge input synchronizer
        pad_in = 32'h0BAD_BEEF;
        tick();
        read_check("R11 one edge", 3'd5, 32'h0000_0000);
        tick();
        read_check("R11 two edges", 3'd5, 32'h0BAD_BEEF);

        // R12: unused selects
        read_check("R12 sel6", 3'd6, '0);
        read_check("R12 sel7", 3'd7, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule